// File: doc/BRIEF.md
# Valve Instruction Execution Unit

This block carries out one valve instruction at a time against a single word-wide data latch. An instruction arrives on a valid/ready channel. Depending on its flag bits, the unit then waits for one item on the incoming channel, may latch that item, and emits zero, one or two 49-bit packets on the outgoing channel. It then reports an outcome (retire, requeue or repeat) back to the instruction ring on a third valid/ready channel. That report carries the instruction word with its count field already updated.

There are two instruction forms. A literal form loads a sign-extended constant into the latch. A normal form is built from seven flags, a 7-bit count and an 11-bit destination. A count at its maximum marks a standing instruction, which never counts down. The parameter `IS_OUTPUT` selects output-port behaviour. On an output port, the destination of a combined data-and-token send is taken from the latch, so the latch contents can route themselves.

Every channel follows the same back-pressure rule. A transfer happens on a clock edge where valid and ready are both high. Once the unit raises a valid, it holds that valid and its payload unchanged until ready is seen. The unit never waits for its own ready before raising valid. Only one of `ins_ready`, `in_ready`, `out_valid` and `res_valid` is high in any cycle.

Top module: `valve_exec`

## Requirements
- R1: After reset, and whenever no instruction is in progress, `ins_ready` is high. While an instruction is in progress `ins_ready` is low, and at most one of `ins_ready`, `in_ready`, `out_valid` and `res_valid` is high.
- R2: A literal instruction has bit 25 = 1. Its bits 19:0, sign-extended from bit 19 to 37 bits, replace the latch. It emits no packet, acknowledges no input, and reports retire (`res_kind` = 0) with the word unchanged.
- R3: In a normal instruction (bit 25 = 0), bit 11 is the token-wait flag and bit 12 is the data-wait flag. If either is set, `in_ready` stays high until one item is accepted, and that single item satisfies the wait. A datum accepted under the token-wait flag alone acts as a token and leaves the latch unchanged.
- R4: The capture flag (bit 13) loads `in_data` into the latch only when the data-wait flag is also set and the accepted item has `in_token` = 0. If a token arrives under capture, the latch keeps its value.
- R5: The data-out flag (bit 14) emits one packet: bit 48 = 0, bits 47:37 = destination field (bits 10:0), bits 36:0 = latch contents after any capture.
- R6: The token-out flag (bit 15) emits a token packet: bit 48 = 1, bits 47:37 = destination, data bits zero. On an input port with both out flags in effect, the data packet is emitted first and the token packet second.
- R7: On an output port, when the data-out flag is set and the token-out flag is in effect, exactly one data packet is emitted, and its path is latch bits 36:26.
- R8: When the ignore flag (bit 16) is set, the token-out flag takes effect only if the count field (bits 24:18) is zero.
- R9: After a normal instruction executes: a count of 0 reports retire. A count from 1 to 126 is reported decremented by one. A count of 127 is reported unchanged. A nonzero count reports requeue (1) if the requeue flag (bit 17) is set, and repeat (2) otherwise.
- R10: These combinations are errors: ignore set with token-out clear, and (on an input port only) both wait flags set. An error reports retire with `res_error` = 1 and the word unchanged. It accepts no input item, emits no packet and leaves the latch unchanged.
- R11: `out_valid` with `out_pkt`, and `res_valid` with `res_kind`, `res_word` and `res_error`, stay high and stable until the matching ready is sampled high.
- R12: Reset clears the latch to zero and lowers `in_ready`, `out_valid` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit idle, instruction accepted on this edge |
| ins_word | input | 26 | Instruction word |
| in_valid | input | 1 | Incoming item offered |
| in_ready | output | 1 | Unit waiting for an incoming item |
| in_token | input | 1 | Incoming item is a token |
| in_data | input | 37 | Incoming datum |
| out_valid | output | 1 | Packet offered |
| out_ready | input | 1 | Fabric takes the packet |
| out_pkt | output | 49 | Token bit, 11-bit path, 37-bit word |
| res_valid | output | 1 | Outcome offered to the ring |
| res_ready | input | 1 | Ring takes the outcome |
| res_kind | output | 2 | 0 retire, 1 requeue, 2 repeat |
| res_word | output | 26 | Instruction with updated count |
| res_error | output | 1 | Invalid flag combination was retired |

## Verification
The hardest state to reach from the ports is a packet held under back-pressure while the latch and the outcome wait behind it. The stimulus holds `out_ready` low across several cycles after a send is accepted, then checks that the packet stays put and that no outcome or new instruction slips through. The other hard case is a latch that must not change: a token under capture, a datum under token-wait, and an error with input offered. Each of these is followed by a plain data send, which exposes the latch contents. The combined send with two packets only exists on an input port, so a second instance of the unit is configured that way and driven through gated handshakes.

// File: rtl/valve_pkg.sv
package valve_pkg;

  typedef enum logic [1:0] {
    OUT_RETIRE  = 2'd0,
    OUT_REQUEUE = 2'd1,
    OUT_REPEAT  = 2'd2
  } outcome_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_IN,
    ST_SEND_DAT,
    ST_SEND_TOK,
    ST_REPORT
  } exec_state_e;

  // flag group of a normal instruction, most significant first
  typedef struct packed {
    logic requeue;
    logic ign_tok;
    logic tok_out;
    logic dat_out;
    logic capture;
    logic dat_wait;
    logic tok_wait;
  } flag_set_t;

  localparam int FLAG_W = 7;

endpackage

// File: rtl/valve_decode.sv
module valve_decode
  import valve_pkg::*;
#(
  parameter int  PATH_W    = 11,
  parameter int  CNT_W     = 7,
  parameter bit  IS_OUTPUT = 1'b1,
  localparam int INS_W     = PATH_W + FLAG_W + CNT_W + 1,
  localparam int LIT_W     = INS_W - 6
) (
  input  logic [INS_W-1:0]  ins,
  output logic              is_lit,
  output logic [LIT_W-1:0]  lit_val,
  output logic [CNT_W-1:0]  cnt,
  output flag_set_t         flags,
  output logic [PATH_W-1:0] dest,
  output logic              bad,
  output logic              need_in,
  output logic              send_dat,
  output logic              send_tok,
  output logic              path_from_latch
);

  logic tok_eff;
  logic cnt_zero;
  logic norm;

  assign is_lit   = ins[INS_W-1];
  assign norm     = ~is_lit;
  assign lit_val  = ins[LIT_W-1:0];
  assign cnt      = ins[INS_W-2 -: CNT_W];
  assign flags    = ins[PATH_W +: FLAG_W];
  assign dest     = ins[PATH_W-1:0];
  assign cnt_zero = (cnt == '0);

  // token output suppressed until the final pass when the ignore flag is set
  assign tok_eff  = flags.tok_out & (~flags.ign_tok | cnt_zero);
  assign need_in  = norm & ~bad & (flags.tok_wait | flags.dat_wait);

  generate
    if (IS_OUTPUT) begin : g_outport
      assign bad             = norm & flags.ign_tok & ~flags.tok_out;
      assign path_from_latch = norm & ~bad & flags.dat_out & tok_eff;
      assign send_dat        = norm & ~bad & flags.dat_out;
      assign send_tok        = norm & ~bad & tok_eff & ~flags.dat_out;
    end else begin : g_inport
      assign bad             = norm & ((flags.ign_tok & ~flags.tok_out) |
                                       (flags.tok_wait & flags.dat_wait));
      assign path_from_latch = 1'b0;
      assign send_dat        = norm & ~bad & flags.dat_out;
      assign send_tok        = norm & ~bad & tok_eff;
    end
  endgenerate

endmodule

// File: rtl/valve_count.sv
module valve_count
  import valve_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             requeue,
  output outcome_e         kind,
  output logic [CNT_W-1:0] next_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    if (cnt == '0) begin
      kind     = OUT_RETIRE;
      next_cnt = cnt;
    end else begin
      kind     = requeue ? OUT_REQUEUE : OUT_REPEAT;
      next_cnt = (cnt == CNT_MAX) ? cnt : cnt - 1'b1;
    end
  end

endmodule

// File: rtl/valve_latch.sv
module valve_latch #(
  parameter int WORD_W = 37,
  parameter int LIT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lit_load,
  input  logic [LIT_W-1:0]  lit_val,
  input  logic              dat_load,
  input  logic [WORD_W-1:0] dat_val,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] lit_ext;

  assign lit_ext = {{(WORD_W-LIT_W){lit_val[LIT_W-1]}}, lit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (lit_load) q <= lit_ext;
    else if (dat_load) q <= dat_val;
  end

endmodule

// File: rtl/valve_exec.sv
module valve_exec
  import valve_pkg::*;
#(
  parameter int WORD_W    = 37,
  parameter int PATH_W    = 11,
  parameter int CNT_W     = 7,
  parameter bit IS_OUTPUT = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ins_valid,
  output logic                            ins_ready,
  input  logic [PATH_W+CNT_W+FLAG_W:0]    ins_word,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic                            in_token,
  input  logic [WORD_W-1:0]               in_data,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [WORD_W+PATH_W:0]          out_pkt,
  output logic                            res_valid,
  input  logic                            res_ready,
  output logic [1:0]                      res_kind,
  output logic [PATH_W+CNT_W+FLAG_W:0]    res_word,
  output logic                            res_error
);

  localparam int INS_W = PATH_W + FLAG_W + CNT_W + 1;
  localparam int LIT_W = INS_W - 6;

  exec_state_e       state_q, state_d;
  logic [INS_W-1:0]  ins_q;
  logic [INS_W-1:0]  dec_in;
  logic [WORD_W-1:0] latch_q;

  logic              is_lit, bad, need_in, send_dat, send_tok, path_from_latch;
  logic [LIT_W-1:0]  lit_val;
  logic [CNT_W-1:0]  cnt, next_cnt;
  flag_set_t         flags;
  logic [PATH_W-1:0] dest;
  outcome_e          cnt_kind;

  logic ins_fire, in_fire, out_fire, res_fire;

  // decode the offered word while idle so no dispatch cycle is spent
  assign dec_in = (state_q == ST_IDLE) ? ins_word : ins_q;

  valve_decode #(.PATH_W(PATH_W), .CNT_W(CNT_W), .IS_OUTPUT(IS_OUTPUT)) u_decode (
    .ins             (dec_in),
    .is_lit          (is_lit),
    .lit_val         (lit_val),
    .cnt             (cnt),
    .flags           (flags),
    .dest            (dest),
    .bad             (bad),
    .need_in         (need_in),
    .send_dat        (send_dat),
    .send_tok        (send_tok),
    .path_from_latch (path_from_latch)
  );

  valve_count #(.CNT_W(CNT_W)) u_count (
    .cnt      (cnt),
    .requeue  (flags.requeue),
    .kind     (cnt_kind),
    .next_cnt (next_cnt)
  );

  assign ins_ready = (state_q == ST_IDLE);
  assign in_ready  = (state_q == ST_WAIT_IN);
  assign out_valid = (state_q == ST_SEND_DAT) || (state_q == ST_SEND_TOK);
  assign res_valid = (state_q == ST_REPORT);

  assign ins_fire = ins_valid & ins_ready;
  assign in_fire  = in_valid  & in_ready;
  assign out_fire = out_valid & out_ready;
  assign res_fire = res_valid & res_ready;

  valve_latch #(.WORD_W(WORD_W), .LIT_W(LIT_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .lit_load (ins_fire & is_lit),
    .lit_val  (lit_val),
    .dat_load (in_fire & flags.dat_wait & flags.capture & ~in_token),
    .dat_val  (in_data),
    .q        (latch_q)
  );

  // next step after the input phase or after the data packet
  function automatic exec_state_e after_input(input logic sd, input logic st);
    if (sd)      return ST_SEND_DAT;
    else if (st) return ST_SEND_TOK;
    else         return ST_REPORT;
  endfunction

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ins_fire) begin
          if (is_lit || bad) state_d = ST_REPORT;
          else if (need_in)  state_d = ST_WAIT_IN;
          else               state_d = after_input(send_dat, send_tok);
        end
      end
      ST_WAIT_IN:  if (in_fire)  state_d = after_input(send_dat, send_tok);
      ST_SEND_DAT: if (out_fire) state_d = send_tok ? ST_SEND_TOK : ST_REPORT;
      ST_SEND_TOK: if (out_fire) state_d = ST_REPORT;
      ST_REPORT:   if (res_fire) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ins_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ins_fire) ins_q <= ins_word;
    end
  end

  // outgoing packet
  logic [PATH_W-1:0] pkt_path;
  assign pkt_path = path_from_latch ? latch_q[WORD_W-1 -: PATH_W] : dest;

  always_comb begin
    if (state_q == ST_SEND_TOK) out_pkt = {1'b1, dest, {WORD_W{1'b0}}};
    else                        out_pkt = {1'b0, pkt_path, latch_q};
  end

  // outcome back to the ring
  logic plain_retire;
  assign plain_retire = is_lit | bad;
  assign res_kind     = plain_retire ? OUT_RETIRE : cnt_kind;
  assign res_error    = bad;
  assign res_word     = plain_retire ? ins_q
                      : {ins_q[INS_W-1], next_cnt, ins_q[INS_W-CNT_W-2:0]};

endmodule

// File: rtl/valve_exec_chk.sv
module valve_exec_chk #(
  parameter int WORD_W = 37,
  parameter int PATH_W = 11,
  parameter int CNT_W  = 7
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             ins_valid,
  input logic                             ins_ready,
  input logic [PATH_W+CNT_W+7:0]          ins_word,
  input logic                             in_ready,
  input logic                             out_valid,
  input logic                             out_ready,
  input logic [WORD_W+PATH_W:0]           out_pkt,
  input logic                             res_valid,
  input logic                             res_ready,
  input logic [1:0]                       res_kind,
  input logic [PATH_W+CNT_W+7:0]          res_word,
  input logic                             res_error
);

  localparam int INS_W = PATH_W + CNT_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [INS_W-1:0] cap_q;
  logic [CNT_W-1:0] cap_cnt, res_cnt, exp_cnt;
  logic             cap_lit, cap_rq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cap_q <= '0;
    else if (ins_valid && ins_ready) cap_q <= ins_word;
  end

  assign cap_lit = cap_q[INS_W-1];
  assign cap_cnt = cap_q[INS_W-2 -: CNT_W];
  assign cap_rq  = cap_q[PATH_W+6];
  assign res_cnt = res_word[INS_W-2 -: CNT_W];
  assign exp_cnt = (cap_cnt == CNT_MAX) ? cap_cnt : cap_cnt - 1'b1;

  assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_ready, in_ready, out_valid, res_valid}));

  assert_lit_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cap_lit |-> res_kind == 2'd0 && res_word == cap_q);

  assert_zero_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !cap_lit && cap_cnt == '0 |-> res_kind == 2'd0);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_error && !cap_lit && cap_cnt != '0
    |-> res_cnt == exp_cnt && res_kind == (cap_rq ? 2'd1 : 2'd2));

  assert_err_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_error |-> res_kind == 2'd0 && res_word == cap_q);

  assert_pkt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pkt));

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable({res_kind, res_word, res_error}));

endmodule

bind valve_exec valve_exec_chk #(.WORD_W(WORD_W), .PATH_W(PATH_W), .CNT_W(CNT_W)) u_valve_exec_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .ins_word  (ins_word),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pkt   (out_pkt),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_kind  (res_kind),
  .res_word  (res_word),
  .res_error (res_error)
);

// File: tb/test_valve_exec.sv
`timescale 1ns/100ps
module test_valve_exec;

  localparam logic [1:0] K_RET = 2'd0, K_REQ = 2'd1, K_REP = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        sel = 1'b0;  // 0: output-port unit, 1: input-port unit
  logic        ins_valid = 0, in_valid = 0, in_token = 0, out_ready = 1, res_ready = 1;
  logic [25:0] ins_word = '0;
  logic [36:0] in_data = '0;

  logic        a_ins_ready, a_in_ready, a_out_valid, a_res_valid, a_res_error;
  logic [48:0] a_out_pkt;
  logic [1:0]  a_res_kind;
  logic [25:0] a_res_word;
  logic        b_ins_ready, b_in_ready, b_out_valid, b_res_valid, b_res_error;
  logic [48:0] b_out_pkt;
  logic [1:0]  b_res_kind;
  logic [25:0] b_res_word;

  valve_exec #(.IS_OUTPUT(1'b1)) i_valve_exec (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid & ~sel), .ins_ready(a_ins_ready), .ins_word(ins_word),
    .in_valid(in_valid & ~sel), .in_ready(a_in_ready), .in_token(in_token), .in_data(in_data),
    .out_valid(a_out_valid), .out_ready(out_ready & ~sel), .out_pkt(a_out_pkt),
    .res_valid(a_res_valid), .res_ready(res_ready & ~sel), .res_kind(a_res_kind),
    .res_word(a_res_word), .res_error(a_res_error));

  valve_exec #(.IS_OUTPUT(1'b0)) i_valve_exec_inport (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid & sel), .ins_ready(b_ins_ready), .ins_word(ins_word),
    .in_valid(in_valid & sel), .in_ready(b_in_ready), .in_token(in_token), .in_data(in_data),
    .out_valid(b_out_valid), .out_ready(out_ready & sel), .out_pkt(b_out_pkt),
    .res_valid(b_res_valid), .res_ready(res_ready & sel), .res_kind(b_res_kind),
    .res_word(b_res_word), .res_error(b_res_error));

  wire        m_ins_ready = sel ? b_ins_ready : a_ins_ready;
  wire        m_in_ready  = sel ? b_in_ready  : a_in_ready;
  wire        m_out_valid = sel ? b_out_valid : a_out_valid;
  wire        m_res_valid = sel ? b_res_valid : a_res_valid;
  wire        m_res_error = sel ? b_res_error : a_res_error;
  wire [48:0] m_out_pkt   = sel ? b_out_pkt   : a_out_pkt;
  wire [1:0]  m_res_kind  = sel ? b_res_kind  : a_res_kind;
  wire [25:0] m_res_word  = sel ? b_res_word  : a_res_word;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // encoders written from the requirement bit positions
  function automatic logic [25:0] nrm(input int c, input bit rq, input bit ig, input bit to,
                                      input bit dd, input bit dc, input bit di, input bit ti,
                                      input int dst);
    return {1'b0, 7'(c), rq, ig, to, dd, dc, di, ti, 11'(dst)};
  endfunction
  function automatic logic [25:0] lit(input logic [19:0] v);
    return {1'b1, 5'b0, v};
  endfunction
  function automatic logic [36:0] sx(input logic [19:0] v);
    return {{17{v[19]}}, v};
  endfunction
  function automatic logic [48:0] pk(input bit t, input logic [10:0] p, input logic [36:0] d);
    return {t, p, d};
  endfunction

  typedef struct packed {
    logic [7:0]  req;
    logic [25:0] w;
    logic        gin;
    logic        tok;
    logic [36:0] d;
    logic        ack;
    logic [1:0]  npk;
    logic [48:0] p0;
    logic [1:0]  kind;
    logic [25:0] rw;
    logic        err;
  } vec_t;

  function automatic vec_t row(input int r, input logic [25:0] w, input bit gin, input bit tok,
                               input logic [36:0] d, input bit ack, input int npk,
                               input logic [48:0] p0, input logic [1:0] kind,
                               input logic [25:0] rw, input bit err);
    return '{8'(r), w, gin, tok, d, ack, 2'(npk), p0, kind, rw, err};
  endfunction

  localparam logic [36:0] L1 = 37'h0_0007_FFFF;
  localparam logic [36:0] L5 = 37'h0_1234_5678;
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    row(2,  lit(20'h7FFFF), 0,0,0, 0, 0, '0, K_RET, lit(20'h7FFFF), 0),                       // R2 positive
    row(5,  nrm(0,0,0,0,1,0,0,0,'h155), 0,0,0, 0, 1, pk(0,11'h155,L1), K_RET,
            nrm(0,0,0,0,1,0,0,0,'h155), 0),                                                   // R5
    row(2,  lit(20'h80001), 0,0,0, 0, 0, '0, K_RET, lit(20'h80001), 0),                       // R2 negative
    row(5,  nrm(0,0,0,0,1,0,0,0,'h2AA), 0,0,0, 0, 1, pk(0,11'h2AA,sx(20'h80001)), K_RET,
            nrm(0,0,0,0,1,0,0,0,'h2AA), 0),                                                   // R5 sign ext
    row(4,  nrm(0,0,0,0,0,1,1,0,0), 1,0,L5, 1, 0, '0, K_RET, nrm(0,0,0,0,0,1,1,0,0), 0),      // R4 capture
    row(5,  nrm(0,0,0,0,1,0,0,0,7), 0,0,0, 0, 1, pk(0,11'h7,L5), K_RET,
            nrm(0,0,0,0,1,0,0,0,7), 0),                                                       // R5
    row(4,  nrm(0,0,0,0,0,1,1,0,0), 1,1,37'h1F_0000_0000, 1, 0, '0, K_RET,
            nrm(0,0,0,0,0,1,1,0,0), 0),                                                       // R4 token
    row(4,  nrm(0,0,0,0,1,0,0,0,1), 0,0,0, 0, 1, pk(0,11'h1,L5), K_RET,
            nrm(0,0,0,0,1,0,0,0,1), 0),                                                       // R4 latch kept
    row(6,  nrm(0,0,0,1,0,0,0,0,'h3C), 0,0,0, 0, 1, pk(1,11'h3C,0), K_RET,
            nrm(0,0,0,1,0,0,0,0,'h3C), 0),                                                    // R6
    row(8,  nrm(5,0,1,1,0,0,0,0,'h11), 0,0,0, 0, 0, '0, K_REP, nrm(4,0,1,1,0,0,0,0,'h11), 0), // R8 held
    row(8,  nrm(0,0,1,1,0,0,0,0,'h11), 0,0,0, 0, 1, pk(1,11'h11,0), K_RET,
            nrm(0,0,1,1,0,0,0,0,'h11), 0),                                                    // R8 last
    row(9,  nrm(127,1,0,0,1,0,0,0,'h22), 0,0,0, 0, 1, pk(0,11'h22,L5), K_REQ,
            nrm(127,1,0,0,1,0,0,0,'h22), 0),                                                  // R9 standing
    row(9,  nrm(1,1,0,0,0,0,0,0,0), 0,0,0, 0, 0, '0, K_REQ, nrm(0,1,0,0,0,0,0,0,0), 0),       // R9
    row(9,  nrm(126,0,0,0,0,0,0,0,0), 0,0,0, 0, 0, '0, K_REP, nrm(125,0,0,0,0,0,0,0,0), 0),   // R9
    row(7,  nrm(0,0,0,1,1,0,0,0,'h0F), 0,0,0, 0, 1, pk(0,L5[36:26],L5), K_RET,
            nrm(0,0,0,1,1,0,0,0,'h0F), 0),                                                    // R7
    row(10, nrm(3,0,1,0,1,0,1,0,9), 1,0,L1, 0, 0, '0, K_RET, nrm(3,0,1,0,1,0,1,0,9), 1),     // R10
    row(3,  nrm(0,0,0,0,0,1,0,1,0), 1,0,37'hABC, 1, 0, '0, K_RET, nrm(0,0,0,0,0,1,0,1,0), 0), // R3 datum as token
    row(3,  nrm(0,0,0,0,1,0,0,0,2), 0,0,0, 0, 1, pk(0,11'h2,L5), K_RET,
            nrm(0,0,0,0,1,0,0,0,2), 0)                                                        // R3 latch kept
  };

  task automatic run_one(input logic [25:0] w, input logic gin, input logic tok, input logic [36:0] d,
                         output int npk, output logic [48:0] p0, output logic [48:0] p1,
                         output logic [1:0] kind, output logic [25:0] rw, output logic err,
                         output logic ack);
    logic done, f_ins, f_in;
    npk = 0; p0 = '0; p1 = '0; kind = '0; rw = '0; err = 0; ack = 0; done = 0;
    ins_word = w; ins_valid = 1; in_token = tok; in_data = d; in_valid = gin;
    out_ready = 1; res_ready = 1;
    for (int i = 0; i < 30 && !done; i++) begin
      @(negedge clk);
      f_ins = ins_valid & m_ins_ready;
      f_in  = in_valid & m_in_ready;
      if (m_out_valid) begin
        if (npk == 0) p0 = m_out_pkt; else p1 = m_out_pkt;
        npk++;
      end
      if (m_res_valid) begin
        kind = m_res_kind; rw = m_res_word; err = m_res_error; done = 1;
      end
      @(posedge clk); #1;
      if (f_ins) ins_valid = 0;
      if (f_in) begin in_valid = 0; ack = 1; end
    end
    ins_valid = 0; in_valid = 0;
    if (!done) check("R1 outcome never reported", 0, 1);
  endtask

  int          npk;
  logic [48:0] p0, p1, hold;
  logic [1:0]  kind;
  logic [25:0] rw;
  logic        err, ack;

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R12 / R1: state while reset is held
    check("R12 in_ready in reset", a_in_ready, 0);
    check("R12 out_valid in reset", a_out_valid, 0);
    check("R12 res_valid in reset", a_res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 ins_ready idle", a_ins_ready, 1);
    check("R1 ins_ready idle inport", b_ins_ready, 1);
    // R12: latch starts at zero
    run_one(nrm(0,0,0,0,1,0,0,0,4), 0,0,0, npk,p0,p1,kind,rw,err,ack);
    check("R12 latch zero after reset", p0, pk(0,11'h4,37'h0));

    foreach (VEC[i]) begin
      run_one(VEC[i].w, VEC[i].gin, VEC[i].tok, VEC[i].d, npk, p0, p1, kind, rw, err, ack);
      check($sformatf("R%0d row %0d packets", VEC[i].req, i), 64'(npk), 64'(VEC[i].npk));
      if (VEC[i].npk != 0) check($sformatf("R%0d row %0d packet", VEC[i].req, i), p0, VEC[i].p0);
      check($sformatf("R%0d row %0d kind", VEC[i].req, i), kind, VEC[i].kind);
      check($sformatf("R%0d row %0d word", VEC[i].req, i), rw, VEC[i].rw);
      check($sformatf("R%0d row %0d error", VEC[i].req, i), err, VEC[i].err);
      check($sformatf("R%0d row %0d input ack", VEC[i].req, i), ack, VEC[i].ack);
    end

    // R10: both wait flags are legal on the output-port unit
    run_one(nrm(0,0,0,0,0,0,1,1,0), 1,0,37'h5, npk,p0,p1,kind,rw,err,ack);
    check("R10 both waits legal on output port err", err, 0);
    check("R10 both waits legal on output port ack", ack, 1);

    // R3 / R1: unit stalls on a data wait without an item
    ins_word = nrm(0,0,0,0,0,1,1,0,0); ins_valid = 1; in_valid = 0;
    @(negedge clk); @(posedge clk); #1; ins_valid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3 in_ready held while waiting", a_in_ready, 1);
      check("R1 ins_ready low while busy", a_ins_ready, 0);
      check("R3 no outcome while waiting", a_res_valid, 0);
    end
    in_token = 0; in_data = 37'h0_0BAD_CAFE; in_valid = 1;
    @(posedge clk); #1; in_valid = 0;
    @(negedge clk);
    check("R3 outcome after item", a_res_valid, 1);
    @(posedge clk); #1;
    run_one(nrm(0,0,0,0,1,0,0,0,3), 0,0,0, npk,p0,p1,kind,rw,err,ack);
    check("R4 late capture", p0, pk(0,11'h3,37'h0_0BAD_CAFE));

    // R11: packet held under back-pressure
    ins_word = nrm(0,0,0,0,1,0,0,0,5); ins_valid = 1; out_ready = 0;
    @(negedge clk); @(posedge clk); #1; ins_valid = 0;
    @(negedge clk);
    check("R11 out_valid raised", a_out_valid, 1);
    hold = a_out_pkt;
    check("R11 packet value", hold, pk(0,11'h5,37'h0_0BAD_CAFE));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 out_valid held", a_out_valid, 1);
      check("R11 packet stable", a_out_pkt, hold);
      check("R11 no outcome during stall", a_res_valid, 0);
    end
    out_ready = 1;
    @(negedge clk);
    check("R11 outcome after release", a_res_valid, 1);
    check("R11 out_valid dropped", a_out_valid, 0);
    @(posedge clk); #1;

    // input-port unit
    sel = 1;
    run_one(lit(20'h00055), 0,0,0, npk,p0,p1,kind,rw,err,ack);
    run_one(nrm(0,0,0,1,1,0,0,0,'h33), 0,0,0, npk,p0,p1,kind,rw,err,ack);
    check("R6 two packets on input port", 64'(npk), 2);
    check("R6 data packet first", p0, pk(0,11'h33,37'h55));
    check("R6 token packet second", p1, pk(1,11'h33,37'h0));
    run_one(nrm(0,0,0,0,0,0,1,1,0), 1,0,37'h9, npk,p0,p1,kind,rw,err,ack);
    check("R10 both waits error on input port", err, 1);
    check("R10 no ack on error", ack, 0);
    check("R10 error retires", kind, K_RET);
    check("R10 no packet on error", 64'(npk), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule